// File: doc/BRIEF.md
# Framed Serial Word Aligner

This block sits after clock recovery on a one-way serial link. Each recovered bit arrives with a one-cycle bit enable. Every transmitted word is wrapped in a 12-bit frame: a start bit of 1, ten payload bits with the least significant bit first, and an end bit of 0. After a power-up settling interval, the aligner looks for the one position in the stream where the framing bits sit correctly. It confirms that position over several words and then reports lock on an active-low flag. While locked, it delivers each payload word in parallel, together with a word-rate strobe whose capture edge can be chosen.

Tri-state pins are not used. Each output group has its own enable flag, and the value of a group is forced to zero while its enable is low. An output-enable input gates only the data and strobe group. The power control input shuts down the whole block, clears the alignment state and disables every output group. A data-valid flag marks the point at which the parallel word can first be trusted: the second capture edge of the strobe after lock is reached.

Top module: `frame_word_aligner`

## Requirements
- R1: A frame holds a start bit of 1, then payload bits 0 to 9 in that order, then an end bit of 0. While locked, `data_out` at each capture edge equals the payload of the most recently completed frame.
- R2: After `pwr_on` rises, `lock_n` stays high for at least SETTLE_WORDS×12 bit enables (2048 word periods by default).
- R3: After settling, with frames carrying all-zero payloads at the input, `lock_n` goes low within 42 word periods. Lock is granted only after 4 consecutive frames pass the framing check at one boundary.
- R4: Once locked, 4 consecutive frames with a wrong framing bit drive `lock_n` high and restart the search. Three bad frames followed by a good one keep the lock.
- R5: `data_vld` is 0 at the first capture edge after `lock_n` falls. It becomes 1 in the cycle of the second capture edge, and it is 0 whenever `lock_n` is high.
- R6: With `strobe_rise_sel`=1, the capture edge is the rising edge of `strobe_out`. With `strobe_rise_sel`=0, it is the falling edge. In both cases `data_out` is stable at the capture edge.
- R7: While locked, `strobe_out` is high for 6 of every 12 bit periods. It stays low while unlocked.
- R8: With `out_en`=0, `data_oe` and `strobe_oe` are 0 and `data_out` and `strobe_out` read 0. `lock_oe` stays 1 and `lock_n` keeps reporting link state.
- R9: With `pwr_on`=0, `lock_oe`, `data_oe` and `strobe_oe` are 0, `data_out` reads 0, and alignment state is cleared, so `lock_n`=1 and `data_vld`=0 from the next cycle on.
- R10: After reset with `pwr_on`=0, `lock_n`=1, `data_vld`=0 and `data_out`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| pwr_on | input | 1 | Block on when 1; low shuts it down |
| out_en | input | 1 | Enables the data and strobe outputs |
| strobe_rise_sel | input | 1 | 1: rising capture edge, 0: falling |
| bit_en | input | 1 | One pulse per recovered serial bit |
| ser_in | input | 1 | Recovered serial bit |
| data_out | output | 10 | Aligned payload word |
| data_oe | output | 1 | Data output group enabled |
| strobe_out | output | 1 | Word-rate strobe |
| strobe_oe | output | 1 | Strobe output enabled |
| data_vld | output | 1 | Payload qualified (second capture edge after lock) |
| lock_n | output | 1 | Lock indicator, active low |
| lock_oe | output | 1 | Lock output enabled |

## Verification
Two things can land on the same clock edge: a frame boundary that updates the alignment state and loads a new word, and a change of the output gating inputs. The bench clears `out_en` while the strobe is toggling and lock is held. It then judges that the data and strobe read zero while `lock_n` keeps its low level, and that the next capture edge after re-enabling carries the current word. It also drops `pwr_on` in the middle of a locked data stream and checks that lock and qualification are gone by the next cycle. A further case lets the third corrupted frame be followed by a good one, and the bench checks that lock survives that boundary.

// File: rtl/fwa_pkg.sv
package fwa_pkg;

    typedef enum logic [1:0] {
        FS_IDLE,
        FS_HUNT,
        FS_CONFIRM,
        FS_LOCKED
    } fwa_state_e;

    typedef struct packed {
        logic start_b;
        logic end_b;
    } fwa_marks_t;

    function automatic logic fwa_marks_ok(input fwa_marks_t m);
        return m.start_b & ~m.end_b;
    endfunction

endpackage

// File: rtl/fwa_settle.sv
module fwa_settle #(
    parameter int LIMIT = 24576
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_on,
    input  logic bit_en,
    output logic settled
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !pwr_on) begin
            cnt <= '0;
        end else if (bit_en && cnt != CW'(LIMIT)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign settled = (cnt == CW'(LIMIT));
endmodule

// File: rtl/fwa_shifter.sv
module fwa_shifter #(
    parameter int FRAME_LEN = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pwr_on,
    input  logic                 bit_en,
    input  logic                 ser_in,
    output logic [FRAME_LEN-1:0] sr,
    output logic                 shifted
);
    always_ff @(posedge clk) begin
        if (rst || !pwr_on) begin
            sr      <= '0;
            shifted <= 1'b0;
        end else begin
            shifted <= bit_en;
            if (bit_en) begin
                sr <= {ser_in, sr[FRAME_LEN-1:1]};
            end
        end
    end
endmodule

// File: rtl/fwa_framer.sv
module fwa_framer
    import fwa_pkg::*;
#(
    parameter int FRAME_LEN     = 12,
    parameter int CONFIRM_WORDS = 4,
    parameter int LOSS_WORDS    = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         pwr_on,
    input  logic                         settled,
    input  logic                         shifted,
    input  fwa_marks_t                   marks,
    output logic                         locked,
    output logic [$clog2(FRAME_LEN)-1:0] phase,
    output logic                         word_load
);
    localparam int PH_W = $clog2(FRAME_LEN);
    localparam int GW   = $clog2(CONFIRM_WORDS + 1);
    localparam int BW   = $clog2(LOSS_WORDS + 1);

    fwa_state_e    state;
    logic [GW-1:0] good_cnt;
    logic [BW-1:0] bad_cnt;
    logic          boundary;
    logic          fr_good;

    assign fr_good  = fwa_marks_ok(marks);
    assign boundary = shifted && (phase == PH_W'(FRAME_LEN - 1));

    always_ff @(posedge clk) begin
        if (rst || !pwr_on) begin
            state    <= FS_IDLE;
            phase    <= '0;
            good_cnt <= '0;
            bad_cnt  <= '0;
        end else begin
            case (state)
                FS_IDLE: begin
                    if (settled) state <= FS_HUNT;
                end
                FS_HUNT: begin
                    if (shifted && fr_good) begin
                        phase    <= '0;
                        good_cnt <= GW'(1);
                        bad_cnt  <= '0;
                        state    <= (CONFIRM_WORDS <= 1) ? FS_LOCKED : FS_CONFIRM;
                    end
                end
                FS_CONFIRM: begin
                    if (shifted) phase <= boundary ? '0 : phase + 1'b1;
                    if (boundary) begin
                        if (!fr_good) begin
                            state <= FS_HUNT;
                        end else if (good_cnt == GW'(CONFIRM_WORDS - 1)) begin
                            state <= FS_LOCKED;
                        end else begin
                            good_cnt <= good_cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    if (shifted) phase <= boundary ? '0 : phase + 1'b1;
                    if (boundary) begin
                        if (fr_good) begin
                            bad_cnt <= '0;
                        end else if (bad_cnt == BW'(LOSS_WORDS - 1)) begin
                            bad_cnt <= '0;
                            state   <= FS_HUNT;
                        end else begin
                            bad_cnt <= bad_cnt + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    assign locked    = (state == FS_LOCKED);
    assign word_load = boundary && (state == FS_CONFIRM || state == FS_LOCKED);
endmodule

// File: rtl/fwa_outstage.sv
module fwa_outstage #(
    parameter int DATA_W    = 10,
    parameter int FRAME_LEN = 12
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         pwr_on,
    input  logic                         locked,
    input  logic                         shifted,
    input  logic [$clog2(FRAME_LEN)-1:0] phase,
    input  logic                         word_load,
    input  logic [DATA_W-1:0]            frame_data,
    input  logic                         rise_sel,
    output logic [DATA_W-1:0]            data_q,
    output logic                         strobe_lvl,
    output logic                         qualified
);
    localparam int PH_W = $clog2(FRAME_LEN);
    localparam int HALF = FRAME_LEN / 2;

    logic [1:0] cap_cnt;
    logic       cap_evt;
    logic       late_half;

    assign cap_evt   = locked && shifted && (phase == PH_W'(HALF - 1));
    assign late_half = (phase >= PH_W'(HALF));

    always_ff @(posedge clk) begin
        if (rst || !pwr_on) begin
            data_q  <= '0;
            cap_cnt <= '0;
        end else begin
            if (word_load) data_q <= frame_data;
            if (!locked) begin
                cap_cnt <= '0;
            end else if (cap_evt && cap_cnt != 2'd2) begin
                cap_cnt <= cap_cnt + 1'b1;
            end
        end
    end

    assign strobe_lvl = locked && (rise_sel ? late_half : !late_half);
    assign qualified  = locked && (cap_cnt == 2'd2);
endmodule

// File: rtl/frame_word_aligner.sv
module frame_word_aligner
    import fwa_pkg::*;
#(
    parameter int DATA_W        = 10,
    parameter int CONFIRM_WORDS = 4,
    parameter int LOSS_WORDS    = 4,
    parameter int SETTLE_WORDS  = 2048
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_on,
    input  logic              out_en,
    input  logic              strobe_rise_sel,
    input  logic              bit_en,
    input  logic              ser_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              strobe_out,
    output logic              strobe_oe,
    output logic              data_vld,
    output logic              lock_n,
    output logic              lock_oe
);
    localparam int FRAME_LEN = DATA_W + 2;
    localparam int PH_W      = $clog2(FRAME_LEN);

    logic [FRAME_LEN-1:0] sr;
    logic                 shifted;
    logic                 settled;
    logic                 locked;
    logic [PH_W-1:0]      phase;
    logic                 word_load;
    logic [DATA_W-1:0]    data_q;
    logic                 strobe_lvl;
    logic                 qualified;
    fwa_marks_t           marks;

    assign marks.start_b = sr[0];
    assign marks.end_b   = sr[FRAME_LEN-1];

    fwa_settle #(.LIMIT(SETTLE_WORDS * FRAME_LEN)) u_settle (
        .clk(clk), .rst(rst), .pwr_on(pwr_on), .bit_en(bit_en), .settled(settled)
    );

    fwa_shifter #(.FRAME_LEN(FRAME_LEN)) u_shift (
        .clk(clk), .rst(rst), .pwr_on(pwr_on), .bit_en(bit_en), .ser_in(ser_in),
        .sr(sr), .shifted(shifted)
    );

    fwa_framer #(
        .FRAME_LEN(FRAME_LEN), .CONFIRM_WORDS(CONFIRM_WORDS), .LOSS_WORDS(LOSS_WORDS)
    ) u_framer (
        .clk(clk), .rst(rst), .pwr_on(pwr_on), .settled(settled), .shifted(shifted),
        .marks(marks), .locked(locked), .phase(phase), .word_load(word_load)
    );

    fwa_outstage #(.DATA_W(DATA_W), .FRAME_LEN(FRAME_LEN)) u_out (
        .clk(clk), .rst(rst), .pwr_on(pwr_on), .locked(locked), .shifted(shifted),
        .phase(phase), .word_load(word_load), .frame_data(sr[DATA_W:1]),
        .rise_sel(strobe_rise_sel), .data_q(data_q), .strobe_lvl(strobe_lvl),
        .qualified(qualified)
    );

    assign data_oe    = pwr_on && out_en;
    assign strobe_oe  = pwr_on && out_en;
    assign lock_oe    = pwr_on;
    assign data_out   = data_oe ? data_q : '0;
    assign strobe_out = strobe_oe && strobe_lvl;
    assign data_vld   = pwr_on && qualified;
    assign lock_n     = !(pwr_on && locked);
endmodule

// File: rtl/fwa_checker.sv
module fwa_checker #(
    parameter int DATA_W       = 10,
    parameter int SETTLE_WORDS = 2048
) (
    input logic              clk,
    input logic              rst,
    input logic              pwr_on,
    input logic              out_en,
    input logic              bit_en,
    input logic [DATA_W-1:0] data_out,
    input logic              strobe_out,
    input logic              data_vld,
    input logic              lock_n
);
    localparam int LIMIT = SETTLE_WORDS * (DATA_W + 2);
    localparam int CW    = $clog2(LIMIT + 1);

    logic [CW-1:0] on_cnt;

    always_ff @(posedge clk) begin
        if (rst || !pwr_on) on_cnt <= '0;
        else if (bit_en && on_cnt != CW'(LIMIT)) on_cnt <= on_cnt + 1'b1;
    end

    // R2
    settle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(lock_n) |-> on_cnt == CW'(LIMIT));

    // R9
    pwrdn_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !pwr_on |=> lock_n && !data_vld);

    // R8
    oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !out_en |-> data_out == '0 && !strobe_out);

    // R5
    vld_locked_chk: assert property (@(posedge clk) disable iff (rst)
        data_vld |-> !lock_n);

    // R7
    idle_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        lock_n |-> !strobe_out);

    // R5
    vld_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(data_vld) && out_en && $past(out_en) |-> !$stable(strobe_out));
endmodule

bind frame_word_aligner fwa_checker #(
    .DATA_W(DATA_W), .SETTLE_WORDS(SETTLE_WORDS)
) u_fwa_chk (
    .clk(clk), .rst(rst), .pwr_on(pwr_on), .out_en(out_en), .bit_en(bit_en),
    .data_out(data_out), .strobe_out(strobe_out), .data_vld(data_vld), .lock_n(lock_n)
);

// File: tb/sim_frame_word_aligner.sv
`timescale 1ns/1ps
module sim_frame_word_aligner;
    localparam int SETTLE = 2048;
    localparam int FLEN   = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwr_on = 1'b0;
    logic       out_en = 1'b1;
    logic       rise_sel = 1'b1;
    logic       bit_en = 1'b1;
    logic       ser_in = 1'b0;
    logic [9:0] data_out;
    logic       data_oe, strobe_out, strobe_oe, data_vld, lock_n, lock_oe;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // stream driver state
    bit         tx_sync   = 1'b1;
    int         bad_left  = 0;
    int         idx       = 0;
    int         frames    = 0;
    logic [9:0] cur_word  = '0;
    logic [9:0] last_done = '0;

    always #2.5 clk = ~clk;

    frame_word_aligner u0 (
        .clk(clk), .rst(rst), .pwr_on(pwr_on), .out_en(out_en),
        .strobe_rise_sel(rise_sel), .bit_en(bit_en), .ser_in(ser_in),
        .data_out(data_out), .data_oe(data_oe), .strobe_out(strobe_out),
        .strobe_oe(strobe_oe), .data_vld(data_vld), .lock_n(lock_n), .lock_oe(lock_oe)
    );

    always @(negedge clk) begin
        if (idx == 0) begin
            cur_word = tx_sync ? 10'd0 : 10'((frames * 37 + 5) % 1024);
            ser_in   = 1'b1;
        end else if (idx <= 10) begin
            ser_in = cur_word[idx-1];
        end else begin
            ser_in    = (bad_left > 0);
            if (bad_left > 0) bad_left = bad_left - 1;
            last_done = cur_word;
            frames    = frames + 1;
        end
        idx = (idx == FLEN - 1) ? 0 : idx + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_frames(input int n);
        int f0 = frames;
        while (frames < f0 + n) @(negedge clk);
    endtask

    // waits for the next capture edge of the currently selected polarity
    task automatic wait_cap(input int limit);
        logic prev = strobe_out;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (rise_sel ? (strobe_out && !prev) : (!strobe_out && prev)) return;
            prev = strobe_out;
        end
    endtask

    task automatic wait_lock(input int limit, output int cycles);
        cycles = 0;
        while (lock_n && cycles < limit) begin
            @(negedge clk);
            cycles++;
        end
    endtask

    task automatic t_reset;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(lock_n == 1'b1, "R10 lock_n", lock_n, 1);
        chk(data_vld == 1'b0, "R10 data_vld", data_vld, 0);
        chk(data_out == 10'd0, "R10 data_out", data_out, 0);
        chk(lock_oe == 1'b0 && data_oe == 1'b0 && strobe_oe == 1'b0, "R9 enables off",
            {lock_oe, data_oe, strobe_oe}, 0);
    endtask

    // R2 / R3: settle then lock on sync frames
    task automatic t_settle_lock;
        int cyc;
        tx_sync = 1'b1;
        pwr_on  = 1'b1;
        wait_lock(SETTLE * FLEN + 60 * FLEN, cyc);
        chk(cyc >= SETTLE * FLEN, "R2 settle hold", cyc, SETTLE * FLEN);
        chk(cyc <= SETTLE * FLEN + 42 * FLEN, "R3 lock time", cyc, SETTLE * FLEN + 42 * FLEN);
    endtask

    // R5 / R6 / R1: qualification and data at capture edges
    task automatic t_qualify(input string tag);
        tx_sync = 1'b0;
        wait_cap(40);
        chk(data_vld == 1'b0, {tag, " R5 first edge"}, data_vld, 0);
        wait_cap(40);
        chk(data_vld == 1'b1, {tag, " R5 second edge"}, data_vld, 1);
        for (int k = 0; k < 6; k++) begin
            chk(data_out == last_done, {tag, " R1 R6 word at edge"}, data_out, last_done);
            wait_cap(40);
        end
    endtask

    task automatic t_duty;
        int hi = 0;
        rise_sel = 1'b1;
        wait_cap(40);
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            if (strobe_out) hi++;
        end
        chk(hi == 12, "R7 strobe duty", hi, 12);
    endtask

    task automatic t_out_en;
        int seen = 0;
        out_en = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (strobe_out || data_out != 10'd0) seen++;
        end
        chk(seen == 0, "R8 gated outputs", seen, 0);
        chk(data_oe == 1'b0 && strobe_oe == 1'b0, "R8 oe flags", {data_oe, strobe_oe}, 0);
        chk(lock_n == 1'b0 && lock_oe == 1'b1, "R8 lock kept", {lock_n, lock_oe}, 1);
        out_en = 1'b1;
        wait_cap(40);
        wait_cap(40);
        chk(data_out == last_done, "R8 R1 data after reenable", data_out, last_done);
    endtask

    task automatic t_loss;
        int cyc;
        bad_left = 3;
        wait_frames(6);
        chk(lock_n == 1'b0, "R4 three bad frames keep lock", lock_n, 0);
        bad_left = 4;
        while (bad_left > 0) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(lock_n == 1'b1, "R4 four bad frames drop lock", lock_n, 1);
        chk(data_vld == 1'b0, "R5 vld cleared on loss", data_vld, 0);
        rise_sel = 1'b0;
        tx_sync  = 1'b1;
        wait_lock(60 * FLEN, cyc);
        chk(cyc <= 43 * FLEN, "R3 relock time", cyc, 43 * FLEN);
    endtask

    task automatic t_pwrdown;
        int early = 0;
        pwr_on = 1'b0;
        repeat (2) @(negedge clk);
        chk(lock_n == 1'b1 && lock_oe == 1'b0, "R9 lock off", {lock_n, lock_oe}, 2);
        chk(data_vld == 1'b0 && data_out == 10'd0, "R9 data cleared", data_out, 0);
        tx_sync = 1'b1;
        pwr_on  = 1'b1;
        for (int i = 0; i < 200 * FLEN; i++) begin
            @(negedge clk);
            if (!lock_n) early++;
        end
        chk(early == 0, "R2 no early lock after repower", early, 0);
    endtask

    initial begin
        t_reset();
        t_settle_lock();
        t_qualify("rise");
        t_duty();
        t_out_en();
        t_loss();
        t_qualify("fall");
        t_pwrdown();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule